// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block times the SCL clock of an I2C master from the peripheral clock. It takes one packed configuration word. The word holds a low-phase divisor, a high-phase divisor, a power-of-two exponent shared by both divisors, and an SDA hold count. Each phase lasts its divisor shifted left by the exponent, plus a fixed implementation offset, counted in peripheral clock cycles. When the two divisors are equal, the SCL frequency is therefore the peripheral clock divided by 2 × (divisor × 2^exponent + offset).

The byte engine starts a bus session with a run request and ends it with a stop request. The configuration is captured only when a session starts. While SCL is low, a strobe tells the byte engine when to change SDA: this happens a programmed hold count plus three cycles after SCL falls. The high-phase count advances only while SCL is sensed high, so a slave that holds SCL low stretches the clock. Strobes mark the first cycle of each low phase and the first cycle in which SCL is seen high.

Top module: `scl_wavegen`

## Requirements
- R1: After reset the block is idle: `busy` is 0, SCL is released (`scl_drive_low` = 0) and no strobe is asserted.
- R2: A low phase lasts exactly (low divisor << exponent) + OFFSET cycles, with OFFSET = 3 by default. `scl_fall_stb` is high in its first cycle only.
- R3: A high phase lasts (high divisor << exponent) + OFFSET cycles in which SCL is sensed high. Cycles in which `scl_in` is low while SCL is released are added to it, so the clock can be stretched.
- R4: Default field positions in `cfg_word`: low divisor in bits 7:0, high divisor in bits 15:8, exponent in bits 18:16, hold count in bits 24:19.
- R5: An exponent field above EXP_MAX (5 by default) is used as EXP_MAX.
- R6: `sda_upd_stb` fires exactly once per low phase. It fires in the cycle whose index from the start of the low phase (first low cycle = 0) equals hold + 3.
- R7: A hold field above HOLD_MAX (40 by default) is used as HOLD_MAX.
- R8: If hold + 3 would land at or past the last low cycle, the update strobe fires in the last low cycle. It never fires outside a low phase.
- R9: The configuration is captured on the run request that starts a session. Changes to `cfg_word` while `busy` is 1 have no effect on that session.
- R10: A stop request made during a session ends it at the end of the high phase in progress or of the next high phase. SCL is then released and `busy` is 0. A run request while busy is ignored.
- R11: `scl_rise_stb` is high in the first high-phase cycle in which `scl_in` is sensed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 2*DIV_W+EXP_W+HOLD_W | Packed divisors, exponent and hold count |
| run_req | input | 1 | Start a session (sampled when idle) |
| stop_req | input | 1 | End the session after a high phase |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| scl_fall_stb | output | 1 | First cycle of a low phase |
| scl_rise_stb | output | 1 | First cycle SCL is sensed high in a high phase |
| sda_upd_stb | output | 1 | SDA may change in this cycle |
| busy | output | 1 | A session is in progress |

## Verification
The run request is sampled at a rising edge, and `scl_drive_low` and `scl_fall_stb` appear in the cycle right after it. The low phase then lasts its full count, and SCL is released in the cycle after the last low cycle. The update strobe is due at cycle index hold + 3 of the low phase, or in the last low cycle when that index is out of range. The rise strobe is due as many cycles into the high phase as the slave stretches it.

The bench samples every output at the falling edge. It counts cycles from the fall strobe and from the release of SCL, and compares each measured phase length and strobe index with values it computes from the configuration word when the session starts. The stretching model changes `scl_in` just after a rising edge, so each stretched cycle is seen by exactly one sampling edge.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   localparam int HOLD_EXTRA = 3;
endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg
   import sclgen_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int EXP_W    = 3,
   parameter int EXP_MAX  = 5,
   parameter int HOLD_W   = 6,
   parameter int HOLD_MAX = 40,
   parameter int OFFSET   = 3,
   parameter int CNT_W    = 15
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  logic                              busy,
   input  logic [2*DIV_W+EXP_W+HOLD_W-1:0]   cfg_word,
   output logic [CNT_W-1:0]                  low_len,
   output logic [CNT_W-1:0]                  high_len,
   output logic [CNT_W-1:0]                  hold_at
);
   localparam int EXP_LSB  = 2 * DIV_W;
   localparam int HOLD_LSB = EXP_LSB + EXP_W;
   localparam logic [CNT_W-1:0] LEN_CAP =
      CNT_W'(((2 ** DIV_W) - 1) * (2 ** EXP_MAX) + OFFSET);

   logic [DIV_W-1:0]  lo_div, hi_div;
   logic [EXP_W-1:0]  exp_raw, exp_eff;
   logic [HOLD_W-1:0] hold_raw, hold_eff;

   assign lo_div   = cfg_word[DIV_W-1:0];
   assign hi_div   = cfg_word[EXP_LSB-1:DIV_W];
   assign exp_raw  = cfg_word[HOLD_LSB-1:EXP_LSB];
   assign hold_raw = cfg_word[HOLD_LSB+HOLD_W-1:HOLD_LSB];

   generate
      if (EXP_MAX < (2 ** EXP_W) - 1) begin : g_exp_sat
         assign exp_eff = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;
      end else begin : g_exp_pass
         assign exp_eff = exp_raw;
      end
      if (HOLD_MAX < (2 ** HOLD_W) - 1) begin : g_hold_sat
         assign hold_eff = (hold_raw > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : hold_raw;
      end else begin : g_hold_pass
         assign hold_eff = hold_raw;
      end
   endgenerate

   logic [CNT_W-1:0] lo_next, hi_next, hold_next;
   assign lo_next   = (CNT_W'(lo_div) << exp_eff) + CNT_W'(OFFSET);
   assign hi_next   = (CNT_W'(hi_div) << exp_eff) + CNT_W'(OFFSET);
   assign hold_next = CNT_W'(hold_eff) + CNT_W'(HOLD_EXTRA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_len  <= CNT_W'(OFFSET);
         high_len <= CNT_W'(OFFSET);
         hold_at  <= CNT_W'(HOLD_EXTRA);
      end else if (load) begin
         low_len  <= lo_next;
         high_len <= hi_next;
         hold_at  <= hold_next;
      end
   end

   initial begin : elab_chk
      assert (OFFSET >= 1) else $error("OFFSET must be at least 1");
      assert (EXP_MAX < 2 ** EXP_W) else $error("EXP_MAX exceeds exponent field");
      assert (CNT_W >= DIV_W + EXP_MAX + 1) else $error("CNT_W too narrow");
      assert (HOLD_MAX + HOLD_EXTRA < 2 ** CNT_W) else $error("HOLD_MAX too large");
   end

   // R9: captured lengths are frozen for the whole session
   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(low_len) && $stable(high_len) && $stable(hold_at)));
   // R5: scaled lengths never exceed the saturated exponent range
   p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (low_len <= LEN_CAP) && (high_len <= LEN_CAP));
   // R7: hold point never exceeds the saturated hold field
   p_hold_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_at <= CNT_W'(HOLD_MAX + HOLD_EXTRA));
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
   import sclgen_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             stop_req,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   output logic             load,
   output logic [CNT_W-1:0] el,
   output logic             in_low,
   output logic             low_last,
   output logic             busy,
   output logic             scl_fall,
   output logic             scl_rise
);
   phase_e ph;
   logic   stop_pend, hi_seen, fall_q;
   logic   hi_last;

   assign load     = (ph == PH_IDLE) && run_req;
   assign in_low   = (ph == PH_LOW);
   assign low_last = in_low && (el == low_len - CNT_W'(1));
   assign hi_last  = (ph == PH_HIGH) && scl_in && (el == high_len - CNT_W'(1));
   assign busy     = (ph != PH_IDLE);
   assign scl_fall = fall_q;
   assign scl_rise = (ph == PH_HIGH) && scl_in && !hi_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         el        <= '0;
         stop_pend <= 1'b0;
         hi_seen   <= 1'b0;
         fall_q    <= 1'b0;
      end else begin
         fall_q <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               stop_pend <= 1'b0;
               if (run_req) begin
                  ph     <= PH_LOW;
                  el     <= '0;
                  fall_q <= 1'b1;
               end
            end
            PH_LOW: begin
               if (stop_req) stop_pend <= 1'b1;
               if (low_last) begin
                  ph      <= PH_HIGH;
                  el      <= '0;
                  hi_seen <= 1'b0;
               end else begin
                  el <= el + CNT_W'(1);
               end
            end
            PH_HIGH: begin
               if (stop_req) stop_pend <= 1'b1;
               if (scl_in) begin
                  hi_seen <= 1'b1;
                  if (hi_last) begin
                     el <= '0;
                     if (stop_pend || stop_req) begin
                        ph        <= PH_IDLE;
                        stop_pend <= 1'b0;
                     end else begin
                        ph     <= PH_LOW;
                        fall_q <= 1'b1;
                     end
                  end else begin
                     el <= el + CNT_W'(1);
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R2: the fall strobe marks the first cycle of a low phase
   p_fall_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall |-> (in_low && el == '0));
   // R2: a low phase is not left before its count ends
   p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_low && !low_last) |=> in_low);
   // R3: sensed-low SCL freezes the high count
   p_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HIGH && !scl_in) |=> (ph == PH_HIGH && $stable(el)));
   // R11: one rise strobe per high phase
   p_rise_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |=> !scl_rise);
   // R10: an idle block never leaves idle without a run request
   p_idle_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !run_req) |=> !busy);
endmodule

// File: rtl/sclgen_hold.sv
module sclgen_hold #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_low,
   input  logic             low_last,
   input  logic [CNT_W-1:0] el,
   input  logic [CNT_W-1:0] hold_at,
   output logic             sda_upd
);
   logic done;

   assign sda_upd = in_low && !done && ((el == hold_at) || low_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done <= 1'b0;
      else if (!in_low)  done <= 1'b0;
      else if (sda_upd)  done <= 1'b1;
   end

   // R6: no second strobe in the same low phase
   p_upd_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_upd && !low_last) |=> !sda_upd);
   // R8: by the last low cycle the strobe has fired or fires now
   p_upd_by_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      low_last |-> (done || sda_upd));
   // R6: a new low phase always starts armed
   p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_low |=> !done);
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
   parameter int DIV_W    = 8,
   parameter int EXP_W    = 3,
   parameter int EXP_MAX  = 5,
   parameter int HOLD_W   = 6,
   parameter int HOLD_MAX = 40,
   parameter int OFFSET   = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [2*DIV_W+EXP_W+HOLD_W-1:0]   cfg_word,
   input  logic                              run_req,
   input  logic                              stop_req,
   input  logic                              scl_in,
   output logic                              scl_drive_low,
   output logic                              scl_fall_stb,
   output logic                              scl_rise_stb,
   output logic                              sda_upd_stb,
   output logic                              busy
);
   localparam int CNT_W = DIV_W + EXP_MAX + 2;

   logic [CNT_W-1:0] low_len, high_len, hold_at, el;
   logic             load, in_low, low_last;

   sclgen_cfg #(
      .DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
      .HOLD_W(HOLD_W), .HOLD_MAX(HOLD_MAX), .OFFSET(OFFSET), .CNT_W(CNT_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .cfg_word(cfg_word),
      .low_len(low_len), .high_len(high_len), .hold_at(hold_at)
   );

   sclgen_phase #(.CNT_W(CNT_W)) phase_i (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .stop_req(stop_req),
      .scl_in(scl_in), .low_len(low_len), .high_len(high_len), .load(load),
      .el(el), .in_low(in_low), .low_last(low_last), .busy(busy),
      .scl_fall(scl_fall_stb), .scl_rise(scl_rise_stb)
   );

   sclgen_hold #(.CNT_W(CNT_W)) hold_i (
      .clk(clk), .rst_n(rst_n), .in_low(in_low), .low_last(low_last),
      .el(el), .hold_at(hold_at), .sda_upd(sda_upd_stb)
   );

   assign scl_drive_low = in_low;

   // R1: SCL is released whenever no session runs
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_drive_low && !sda_upd_stb));
endmodule

// File: tb/scl_wavegen_tb_top.sv
module scl_wavegen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [24:0] cfg_word = '0;
   logic        run_req = 1'b0, stop_req = 1'b0, stretch = 1'b0;
   logic        scl_in;
   logic        scl_drive_low, scl_fall_stb, scl_rise_stb, sda_upd_stb, busy;

   int n_chk = 0, n_err = 0, cyc = 0;
   int exp_low = 0, exp_high = 0, exp_upd = 0, stretch_n = 0;
   int lo_c = 0, hi_c = 0, upd_i = 0, upd_n = 0, falls = 0;
   int last_low = 0, last_upd = 0, str_left = 0;
   bit hi_act = 0, pdrv = 0, sdrv = 0;

   always #4 clk = ~clk;

   assign scl_in = !scl_drive_low && !stretch;

   scl_wavegen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .run_req(run_req),
      .stop_req(stop_req), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
      .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb),
      .sda_upd_stb(sda_upd_stb), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int f_len(input int dv, input int ex);
      int e = (ex > 5) ? 5 : ex;
      return (dv << e) + 3;
   endfunction

   function automatic int f_upd(input int ho, input int lowlen);
      int h = ((ho > 40) ? 40 : ho) + 3;
      return (h > lowlen - 1) ? lowlen - 1 : h;
   endfunction

   function automatic logic [24:0] mk(input int lo, input int hi, input int ex, input int ho);
      return {ho[5:0], ex[2:0], hi[7:0], lo[7:0]};
   endfunction

   // slave stretching model: updates just after the rising edge
   always @(posedge clk) begin
      #1;
      if (sdrv && !scl_drive_low) str_left = stretch_n;
      if (str_left > 0) begin
         stretch = 1'b1;
         str_left--;
      end else begin
         stretch = 1'b0;
      end
      sdrv = scl_drive_low;
   end

   // phase monitor sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_drive_low) begin
            if (!pdrv) begin
               if (hi_act) begin
                  chk(hi_c == exp_high + stretch_n, "R3 high length", hi_c, exp_high + stretch_n);
                  hi_act = 0;
               end
               chk(scl_fall_stb, "R2 fall strobe", int'(scl_fall_stb), 1);
               lo_c = 0; upd_n = 0; upd_i = -1; falls++;
            end
            if (sda_upd_stb) begin upd_i = lo_c; upd_n++; end
            lo_c++;
         end else begin
            if (pdrv) begin
               chk(lo_c == exp_low, "R2 R4 low length", lo_c, exp_low);
               chk(upd_n == 1, "R6 updates per low phase", upd_n, 1);
               chk(upd_i == exp_upd, "R6 update index", upd_i, exp_upd);
               last_low = lo_c; last_upd = upd_i;
               hi_act = 1; hi_c = 0;
            end
            if (sda_upd_stb) chk(0, "R8 update outside low phase", 1, 0);
            if (hi_act) begin
               if (busy) begin
                  if (scl_rise_stb) chk(hi_c == stretch_n, "R11 rise index", hi_c, stretch_n);
                  hi_c++;
               end else begin
                  chk(hi_c == exp_high + stretch_n, "R3 high length", hi_c, exp_high + stretch_n);
                  hi_act = 0;
               end
            end
         end
         pdrv = scl_drive_low;
      end
   end

   task automatic session(input logic [24:0] w, input int nper, input int s, input bit garble);
      exp_low   = f_len(int'(w[7:0]), int'(w[18:16]));
      exp_high  = f_len(int'(w[15:8]), int'(w[18:16]));
      exp_upd   = f_upd(int'(w[24:19]), exp_low);
      stretch_n = s;
      cfg_word  = w;
      falls     = 0;
      @(negedge clk) run_req = 1'b1;
      @(negedge clk) run_req = 1'b0;
      if (garble) begin
         cfg_word = 25'($urandom);
         run_req  = 1'b1;
         @(negedge clk) run_req = 1'b0;
      end
      while (falls < nper) @(negedge clk);
      @(negedge clk) stop_req = 1'b1;
      @(negedge clk) stop_req = 1'b0;
      while (busy) @(negedge clk);
      chk(falls == nper, "R10 periods before stop", falls, nper);
      chk(!scl_drive_low, "R10 released after stop", int'(scl_drive_low), 0);
      if (garble) chk(last_low == exp_low, "R9 config frozen while busy", last_low, exp_low);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(!busy && !scl_drive_low, "R1 reset idle", int'(busy), 0);
      chk(!scl_fall_stb && !scl_rise_stb && !sda_upd_stb, "R1 reset strobes",
          int'(scl_fall_stb | scl_rise_stb | sda_upd_stb), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !scl_drive_low, "R1 idle after reset release", int'(busy), 0);

      session(mk(10, 20, 7, 1), 2, 0, 0);
      chk(last_low == 323, "R5 exponent saturation", last_low, 323);
      session(mk(200, 4, 0, 63), 1, 0, 0);
      chk(last_upd == 43, "R7 hold saturation", last_upd, 43);
      session(mk(5, 0, 0, 20), 2, 2, 0);
      chk(last_upd == 7, "R8 clamp to last low cycle", last_upd, 7);
      session(mk(0, 0, 0, 0), 2, 0, 0);
      chk(last_upd == 2, "R8 clamp minimum phase", last_upd, 2);
      session(mk(50, 9, 0, 0), 2, 5, 1);
      chk(last_upd == 3, "R6 zero hold index", last_upd, 3);

      for (int i = 0; i < 12; i++) begin
         logic [24:0] w;
         w = 25'($urandom);
         w[18:16] = 3'($urandom_range(0, 2));
         session(w, 2 + (i % 2), (i % 3 == 0) ? int'($urandom_range(1, 9)) : 0, (i % 4) == 1);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule